// File: doc/BRIEF.md
# Synthesizer Programming Register Interface

This block is a write-only two-wire serial slave that loads the programming registers of a PLL frequency synthesizer. It over-samples the serial clock and data lines with the system clock and finds START and STOP conditions. It matches a 7-bit device address whose two low bits come from a board-level select, and it pulls the data line low to acknowledge each accepted byte. Accepted data bytes are written into a shadow register set.

Four kinds of data byte exist: two that hold the 17-bit divide ratio (high part and low part) and two that hold control fields. The first data byte of a transfer, and any byte that follows a low-divider byte or a second control byte, is steered by its own MSB. The bytes that follow are taken in order, so one transfer can program everything with a single address byte. The control fields take effect as soon as their byte is acknowledged. The divide ratio is moved from shadow to the active register only when a complete pair of byte groups has arrived, or at STOP, so that a running frequency sweep never sees a half-written ratio.

Top module: `synth_prog_if`

## Requirements
- R1: In reset and immediately after it, the data-line pull-down is released and every output register (divide ratio and all control fields) holds zero.
- R2: An address byte equal to binary 11000, then the two `addr_sel` bits, then a 0 write bit (sent MSB first) is acknowledged: `sda_oe` is high while SCL is high during the ninth clock.
- R3: An address byte with other device bits, or with the write bit at 1, gets no acknowledge, and every following byte up to the next START is neither acknowledged nor stored.
- R4: The sequence high-divider, low-divider, control-A, control-B in one transfer updates the active ratio before STOP. The ratio is {control-A bits 6:5, high-divider bits 6:0, low-divider bits 7:0}.
- R5: A steered byte with MSB 0 is a high-divider byte and one with MSB 1 is control-A. Control-A carries ratio bits 16:15 in bits 6:5, the prescaler enable in bit 4 and the reference select in bits 3:0.
- R6: Every data byte received after an accepted address is acknowledged on its ninth clock.
- R7: Resending high-divider and low-divider bytes within one transfer, with no control byte, leaves the active ratio unchanged until STOP.
- R8: Control-A, control-B, high-divider, low-divider in one transfer updates the active ratio on the low-divider byte, before STOP.
- R9: At STOP, the active ratio takes the shadow value if any divider byte (high, low or control-A) arrived since the last ratio update.
- R10: Control-B drives the charge-pump current (bits 7:6), the oscillator output enable (bit 5), the oscillator select (bit 4) and the port bits (3:0). These fields and the control-A fields change on their byte's acknowledge, without waiting for STOP.
- R11: A repeated START restarts steering, so the next data byte is steered by its MSB even when a low-divider byte was expected.
- R12: After a high-divider byte the next byte is the low-divider byte. After control-A it is control-B. After low-divider or control-B the next byte is steered by its MSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line, asynchronous |
| sda_in | input | 1 | Serial data line as seen on the bus, asynchronous |
| addr_sel | input | 2 | Board select for the two low address bits |
| sda_oe | output | 1 | High pulls the data line low (acknowledge) |
| div_ratio | output | 17 | Active divide ratio |
| prescaler_on | output | 1 | Prescaler enable |
| ref_sel | output | 4 | Reference divider select |
| pump_cur | output | 2 | Charge-pump current select |
| osc_en | output | 1 | Oscillator output enable |
| osc_sel | output | 1 | Oscillator select |
| port_out | output | 4 | General port bits |

## Verification
Directed transfers apply the byte orders that matter to the update rule. A full in-order group pair and the reversed pair each show that the ratio moves before STOP. A repeated high/low pair shows that the ratio holds until STOP. Single-group transfers ended by STOP show the pending-commit path. A wrong device address and a read request show that the bus is ignored. A repeated START placed where a low-divider byte was due tells a steering reset from a simple byte counter.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
  localparam int RATIO_W = 17;

  typedef enum logic [1:0] {
    BUS_IDLE,
    BUS_ADDR,
    BUS_DATA,
    BUS_SKIP
  } bus_state_e;

  typedef enum logic [1:0] {
    SLOT_STEER,
    SLOT_AFTER_HI,
    SLOT_AFTER_CA
  } slot_e;

  typedef enum logic [1:0] {
    KIND_HI,
    KIND_LO,
    KIND_CA,
    KIND_CB
  } byte_kind_e;
endpackage

// File: rtl/spb_line_cond.sv
module spb_line_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LINES = 2;
  localparam int TOP = SYNC_STAGES - 1;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] synced;
  logic scl_q, sda_q;

  assign raw = {scl_in, sda_in};

  genvar g;
  generate
    for (g = 0; g < LINES; g++) begin : g_sync
      logic [SYNC_STAGES-1:0] chain;
      if (SYNC_STAGES > 1) begin : g_multi
        always_ff @(posedge clk) begin
          if (rst) chain <= '1;
          else     chain <= {chain[SYNC_STAGES-2:0], raw[g]};
        end
      end else begin : g_single
        always_ff @(posedge clk) begin
          if (rst) chain <= '1;
          else     chain <= raw[g];
        end
      end
      assign synced[g] = chain[TOP];
    end
  endgenerate

  assign scl_lvl = synced[1];
  assign sda_lvl = synced[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_lvl;
      sda_q <= sda_lvl;
    end
  end

  assign scl_rise  = scl_lvl & ~scl_q;
  assign scl_fall  = ~scl_lvl & scl_q;
  assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/spb_byte_slave.sv
module spb_byte_slave
  import synth_prog_pkg::*;
#(
  parameter logic [4:0] DEV_BASE = 5'b11000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sda_lvl,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [1:0] addr_sel,
  output logic       sda_oe,
  output logic       byte_stb,
  output logic [7:0] byte_val,
  output logic       xfer_start,
  output logic       skipping
);
  localparam int BITS = 8;
  localparam int CNT_W = $clog2(BITS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BITS);

  bus_state_e       state;
  logic [CNT_W-1:0] bitcnt;
  logic             ack_ph;
  logic [7:0]       shreg;
  logic             addr_ok;

  assign addr_ok  = (shreg[7:1] == {DEV_BASE, addr_sel}) && !shreg[0];
  assign skipping = (state == BUS_SKIP);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= BUS_IDLE;
      bitcnt     <= '0;
      ack_ph     <= 1'b0;
      shreg      <= '0;
      sda_oe     <= 1'b0;
      byte_stb   <= 1'b0;
      byte_val   <= '0;
      xfer_start <= 1'b0;
    end else begin
      byte_stb   <= 1'b0;
      xfer_start <= 1'b0;
      if (start_det) begin
        state      <= BUS_ADDR;
        bitcnt     <= '0;
        ack_ph     <= 1'b0;
        sda_oe     <= 1'b0;
        xfer_start <= 1'b1;
      end else if (stop_det) begin
        state  <= BUS_IDLE;
        bitcnt <= '0;
        ack_ph <= 1'b0;
        sda_oe <= 1'b0;
      end else if (state == BUS_ADDR || state == BUS_DATA) begin
        if (scl_rise && !ack_ph && bitcnt != LAST) begin
          shreg  <= {shreg[6:0], sda_lvl};
          bitcnt <= bitcnt + 1'b1;
        end else if (scl_fall && ack_ph) begin
          ack_ph <= 1'b0;
          sda_oe <= 1'b0;
          bitcnt <= '0;
          if (state == BUS_ADDR) state <= BUS_DATA;
        end else if (scl_fall && bitcnt == LAST) begin
          if (state == BUS_ADDR) begin
            if (addr_ok) begin
              ack_ph <= 1'b1;
              sda_oe <= 1'b1;
            end else begin
              state <= BUS_SKIP;
            end
          end else begin
            ack_ph   <= 1'b1;
            sda_oe   <= 1'b1;
            byte_stb <= 1'b1;
            byte_val <= shreg;
          end
        end
      end
    end
  end
endmodule

// File: rtl/spb_reg_bank.sv
module spb_reg_bank
  import synth_prog_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               byte_stb,
  input  logic [7:0]         byte_val,
  input  logic               xfer_start,
  input  logic               stop_det,
  output logic [RATIO_W-1:0] div_ratio,
  output logic               prescaler_on,
  output logic [3:0]         ref_sel,
  output logic [1:0]         pump_cur,
  output logic               osc_en,
  output logic               osc_sel,
  output logic [3:0]         port_out,
  output logic               commit_req
);
  slot_e              slot;
  byte_kind_e         kind;
  logic [RATIO_W-1:0] shadow;
  logic               got_lo, got_hi, got_div;

  always_comb begin
    unique case (slot)
      SLOT_AFTER_HI: kind = KIND_LO;
      SLOT_AFTER_CA: kind = KIND_CB;
      default:       kind = byte_val[7] ? KIND_CA : KIND_HI;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot         <= SLOT_STEER;
      shadow       <= '0;
      div_ratio    <= '0;
      prescaler_on <= 1'b0;
      ref_sel      <= '0;
      pump_cur     <= '0;
      osc_en       <= 1'b0;
      osc_sel      <= 1'b0;
      port_out     <= '0;
      got_lo       <= 1'b0;
      got_hi       <= 1'b0;
      got_div      <= 1'b0;
      commit_req   <= 1'b0;
    end else begin
      commit_req <= 1'b0;
      if (commit_req) div_ratio <= shadow;
      if (xfer_start) begin
        slot <= SLOT_STEER;
      end else if (stop_det) begin
        slot       <= SLOT_STEER;
        commit_req <= got_div;
        got_lo     <= 1'b0;
        got_hi     <= 1'b0;
        got_div    <= 1'b0;
      end else if (byte_stb) begin
        unique case (kind)
          KIND_HI: begin
            shadow[14:8] <= byte_val[6:0];
            slot         <= SLOT_AFTER_HI;
            got_lo       <= 1'b1;
            got_div      <= 1'b1;
          end
          KIND_LO: begin
            shadow[7:0] <= byte_val;
            slot        <= SLOT_STEER;
            if (got_hi) begin
              commit_req <= 1'b1;
              got_lo     <= 1'b0;
              got_hi     <= 1'b0;
              got_div    <= 1'b0;
            end else begin
              got_lo  <= 1'b1;
              got_div <= 1'b1;
            end
          end
          KIND_CA: begin
            shadow[16:15] <= byte_val[6:5];
            prescaler_on  <= byte_val[4];
            ref_sel       <= byte_val[3:0];
            slot          <= SLOT_AFTER_CA;
            got_hi        <= 1'b1;
            got_div       <= 1'b1;
          end
          default: begin
            pump_cur <= byte_val[7:6];
            osc_en   <= byte_val[5];
            osc_sel  <= byte_val[4];
            port_out <= byte_val[3:0];
            slot     <= SLOT_STEER;
            if (got_lo) begin
              commit_req <= 1'b1;
              got_lo     <= 1'b0;
              got_hi     <= 1'b0;
              got_div    <= 1'b0;
            end else begin
              got_hi <= 1'b1;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/synth_prog_if.sv
module synth_prog_if
  import synth_prog_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [4:0] DEV_BASE    = 5'b11000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_in,
  input  logic               sda_in,
  input  logic [1:0]         addr_sel,
  output logic               sda_oe,
  output logic [RATIO_W-1:0] div_ratio,
  output logic               prescaler_on,
  output logic [3:0]         ref_sel,
  output logic [1:0]         pump_cur,
  output logic               osc_en,
  output logic               osc_sel,
  output logic [3:0]         port_out
);
  logic       scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic       byte_stb, xfer_start, skipping, commit_req;
  logic [7:0] byte_val;

  spb_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_line (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  spb_byte_slave #(.DEV_BASE(DEV_BASE)) u_slave (
    .clk(clk), .rst(rst), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .addr_sel(addr_sel), .sda_oe(sda_oe), .byte_stb(byte_stb),
    .byte_val(byte_val), .xfer_start(xfer_start), .skipping(skipping)
  );

  spb_reg_bank u_bank (
    .clk(clk), .rst(rst), .byte_stb(byte_stb), .byte_val(byte_val),
    .xfer_start(xfer_start), .stop_det(stop_det), .div_ratio(div_ratio),
    .prescaler_on(prescaler_on), .ref_sel(ref_sel), .pump_cur(pump_cur),
    .osc_en(osc_en), .osc_sel(osc_sel), .port_out(port_out),
    .commit_req(commit_req)
  );
endmodule

// File: rtl/synth_prog_chk.sv
module synth_prog_chk
  import synth_prog_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               scl_lvl,
  input logic               scl_rise,
  input logic               sda_oe,
  input logic               skipping,
  input logic               byte_stb,
  input logic               stop_det,
  input logic               commit_req,
  input logic [RATIO_W-1:0] div_ratio
);
  a_r1_reset_releases: assert property (@(posedge clk)
    rst |=> !sda_oe);

  a_r6_oe_steady_scl_high: assert property (@(posedge clk) disable iff (rst)
    (scl_lvl && !scl_rise) |-> $stable(sda_oe));

  a_r3_skip_silent: assert property (@(posedge clk) disable iff (rst)
    skipping |-> !sda_oe);

  a_r9_ratio_moves_on_commit: assert property (@(posedge clk) disable iff (rst)
    (div_ratio != $past(div_ratio)) |-> $past(commit_req));

  a_r4_commit_has_cause: assert property (@(posedge clk) disable iff (rst)
    commit_req |-> $past(byte_stb || stop_det));
endmodule

bind synth_prog_if synth_prog_chk u_chk (
  .clk(clk), .rst(rst), .scl_lvl(scl_lvl), .scl_rise(scl_rise),
  .sda_oe(sda_oe), .skipping(skipping), .byte_stb(byte_stb),
  .stop_det(stop_det), .commit_req(commit_req), .div_ratio(div_ratio)
);

// File: tb/sim_synth_prog_if.sv
module sim_synth_prog_if;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam logic [7:0] MY_ADDR = 8'hC4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic [1:0]  addr_sel = 2'b10;
  logic        sda_oe;
  logic [16:0] div_ratio;
  logic        prescaler_on, osc_en, osc_sel;
  logic [3:0]  ref_sel, port_out;
  logic [1:0]  pump_cur;
  logic        sda_line;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  assign sda_line = sda_m & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  synth_prog_if u0 (
    .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line),
    .addr_sel(addr_sel), .sda_oe(sda_oe), .div_ratio(div_ratio),
    .prescaler_on(prescaler_on), .ref_sel(ref_sel), .pump_cur(pump_cur),
    .osc_en(osc_en), .osc_sel(osc_sel), .port_out(port_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_q(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wait_q(Q);
    scl_m = 1'b1; wait_q(Q);
    sda_m = 1'b0; wait_q(Q);
    scl_m = 1'b0; wait_q(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wait_q(Q);
    scl_m = 1'b1; wait_q(Q);
    sda_m = 1'b1; wait_q(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_q(Q);
      scl_m = 1'b1; wait_q(Q);
      scl_m = 1'b0; wait_q(Q);
    end
    sda_m = 1'b1; wait_q(Q);
    scl_m = 1'b1; wait_q(Q/2);
    acked = sda_oe;
    wait_q(Q/2);
    scl_m = 1'b0; wait_q(Q);
  endtask

  task automatic send_chk(input logic [7:0] b, input logic exp_ack, input string req);
    logic a;
    send_byte(b, a);
    chk(req, int'(a), int'(exp_ack));
  endtask

  task automatic t_reset;
    chk("R1 sda_oe", int'(sda_oe), 0);
    chk("R1 ratio", int'(div_ratio), 0);
    chk("R1 controls", int'({prescaler_on, ref_sel, pump_cur, osc_en, osc_sel, port_out}), 0);
  endtask

  task automatic t_full_pair;
    bus_start;
    send_chk(MY_ADDR, 1'b1, "R2 address ack");
    send_chk(8'h12, 1'b1, "R6 ack hi");
    send_chk(8'h34, 1'b1, "R6 ack lo");
    send_chk(8'hD5, 1'b1, "R6 ack ctlA");
    chk("R5 prescaler", int'(prescaler_on), 1);
    chk("R5 ref_sel", int'(ref_sel), 5);
    send_chk(8'h9A, 1'b1, "R6 ack ctlB");
    chk("R4 ratio before stop", int'(div_ratio), 70196);
    chk("R10 pump_cur", int'(pump_cur), 2);
    chk("R10 osc_en/osc_sel", int'({osc_en, osc_sel}), 1);
    chk("R10 port_out", int'(port_out), 10);
    bus_stop;
    chk("R4 ratio after stop", int'(div_ratio), 70196);
  endtask

  task automatic t_repeat_hi_lo;
    bus_start;
    send_chk(MY_ADDR, 1'b1, "R2 address ack");
    send_chk(8'h05, 1'b1, "R6 ack");
    send_chk(8'h06, 1'b1, "R6 ack");
    send_chk(8'h07, 1'b1, "R6 ack");
    send_chk(8'h08, 1'b1, "R6 ack");
    chk("R7 ratio held", int'(div_ratio), 70196);
    bus_stop;
    chk("R9 ratio at stop", int'(div_ratio), 67336);
  endtask

  task automatic t_reverse_pair;
    bus_start;
    send_chk(MY_ADDR, 1'b1, "R2 address ack");
    send_chk(8'hA3, 1'b1, "R6 ack");
    send_chk(8'h45, 1'b1, "R12 ack ctlB");
    chk("R10 ref_sel", int'(ref_sel), 3);
    chk("R10 ctlB fields", int'({pump_cur, osc_en, osc_sel, port_out}), 8'h45);
    chk("R8 ratio held mid", int'(div_ratio), 67336);
    send_chk(8'h01, 1'b1, "R12 ack hi");
    send_chk(8'h02, 1'b1, "R12 ack lo");
    chk("R8 ratio before stop", int'(div_ratio), 33026);
    bus_stop;
  endtask

  task automatic t_ctla_stop;
    bus_start;
    send_chk(MY_ADDR, 1'b1, "R2 address ack");
    send_chk(8'hC0, 1'b1, "R6 ack");
    chk("R9 ratio before stop", int'(div_ratio), 33026);
    bus_stop;
    chk("R9 ratio after ctlA stop", int'(div_ratio), 65794);
  endtask

  task automatic t_foreign;
    bus_start;
    send_chk(8'hC0, 1'b0, "R3 other address");
    send_chk(8'h7F, 1'b0, "R3 skipped byte");
    send_chk(8'h80, 1'b0, "R3 skipped byte");
    bus_stop;
    bus_start;
    send_chk(8'hC5, 1'b0, "R3 read request");
    send_chk(8'h00, 1'b0, "R3 skipped byte");
    bus_stop;
    chk("R3 ratio kept", int'(div_ratio), 65794);
    chk("R3 controls kept", int'({prescaler_on, ref_sel}), 0);
  endtask

  task automatic t_restart;
    bus_start;
    send_chk(MY_ADDR, 1'b1, "R2 address ack");
    send_chk(8'h03, 1'b1, "R6 ack");
    bus_start;
    send_chk(MY_ADDR, 1'b1, "R11 address ack");
    send_chk(8'h81, 1'b1, "R11 ack");
    chk("R11 steered to ctlA", int'(ref_sel), 1);
    bus_stop;
    chk("R11 ratio at stop", int'(div_ratio), 770);
  endtask

  task automatic t_three_stop;
    bus_start;
    send_chk(MY_ADDR, 1'b1, "R2 address ack");
    send_chk(8'h00, 1'b1, "R6 ack");
    send_chk(8'hFF, 1'b1, "R6 ack");
    send_chk(8'hE0, 1'b1, "R12 ack ctlA");
    chk("R9 ratio before stop", int'(div_ratio), 770);
    bus_stop;
    chk("R9 ratio after stop", int'(div_ratio), 98559);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset;
    rst = 1'b0;
    wait_q(4);
    t_reset;
    t_full_pair;
    t_repeat_hi_lo;
    t_reverse_pair;
    t_ctla_stop;
    t_foreign;
    t_restart;
    t_three_stop;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule